// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of read-only configuration bytes as soon as reset is released. It has two sources. In the first, it reads the bytes one at a time from an external serial EEPROM. The EEPROM link has four wires: an active-high select, a serial clock that the loader drives, a command line toward the EEPROM, and a data line back from it. In the second, it writes a fixed set of built-in defaults and never touches the EEPROM.

A single source-select input chooses between the two. The loader samples it once per reset. When every byte is in place, the loader raises a done flag. Bus logic elsewhere uses that flag to decide when configuration accesses may be answered.

The bank is read through a plain word-wide port with no stall. A read made during loading returns whatever the bank holds at that moment: bytes not yet loaded read as zero. No data stream crosses the block edge, so there is no valid/ready handshake. The configuration port is a combinational register read, and the EEPROM link is clocked entirely by the loader.

Top module: `cfgld_loader`

## Requirements
- R1: When the source select is 1, the loader reads EEPROM addresses 0 to NBYTES-1 in ascending order, one byte per select window. Each window carries, MSB first, the read opcode 3'b110 and then a ROM_AW-bit address on `rom_sdo`, followed by 8 data bits from `rom_sdi`, also MSB first.
- R2: `rom_sdo` changes only while `rom_clk` is low. `rom_sdi` is sampled in the system cycle that raises `rom_clk`. Each high and each low phase of `rom_clk` lasts HALF_DIV system cycles. `rom_clk` is low whenever `rom_sel` is low.
- R3: `rom_sel` is active high. It is 0 in reset, high for the whole of a byte transfer, and low for at least two system cycles between transfers.
- R4: Configuration byte i holds the byte read from EEPROM address i. `cfg_data` for word w carries byte 4w in bits 7:0, 4w+1 in 15:8, 4w+2 in 23:16 and 4w+3 in 31:24.
- R5: When the source select is 0, `rom_sel` never rises and the defaults are loaded instead. Byte 0 = 10h, byte 1 = 97h, byte 2 = 05h, byte 3 = 98h, byte 8 = 01h, byte 9 = 02h, byte 10 = 01h, byte 11 = 07h, byte 61 = 01h; every other byte is 00h. This gives word 0 = 98059710h, word 2 = 07010201h and word 15 = 00000100h.
- R6: The source select is sampled only in the first clock after reset release. Later changes have no effect until the next reset.
- R7: `load_done` is 0 from reset until the last byte is written, then 1 until the next reset. While it is 1, `rom_sel` stays low.
- R8: All configuration bytes reset to 00h. Reads made before `load_done` return the current contents in the same cycle.
- R9: Asserting reset during a load clears the bank and stops the transfer. After release, loading restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_rom | input | 1 | 1 = load from EEPROM, 0 = load defaults; tie high when unused |
| rom_sel | output | 1 | EEPROM select, active high |
| rom_clk | output | 1 | EEPROM serial clock |
| rom_sdo | output | 1 | Opcode and address bits toward the EEPROM |
| rom_sdi | input | 1 | Data bits from the EEPROM |
| cfg_word | input | $clog2(NBYTES/4) | Configuration word index |
| cfg_data | output | 32 | Configuration word contents |
| load_done | output | 1 | Loading finished |

## Verification
The bench builds the loader with NBYTES = 64, ROM_AW = 6 and HALF_DIV = 2. This is the full 64-byte image with a 9-bit command. The short divider keeps each full EEPROM load to a few thousand cycles. That makes room for three complete loads in one run: one from a first image, one restarted mid-transfer from a second image, and one from defaults. A behavioural EEPROM answers on the serial pins, and a scoreboard compares every captured command against the expected ascending address list.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

  localparam int            OP_W      = 3;
  localparam logic [OP_W-1:0] ROM_RD_OP = 3'b110;

  typedef enum logic [1:0] {SQ_PICK, SQ_ROM, SQ_DEF, SQ_FIN} seq_st_e;
  typedef enum logic [1:0] {SR_IDLE, SR_SHIFT, SR_GAP}       ser_st_e;

  // Built-in configuration image used when the EEPROM is not selected.
  function automatic logic [7:0] dflt_byte(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h97;
      2:       return 8'h05;
      3:       return 8'h98;
      8:       return 8'h01;
      9:       return 8'h02;
      10:      return 8'h01;
      11:      return 8'h07;
      61:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgld_tick.sv
`timescale 1ns/1ps
module cfgld_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfgld_serial.sv
`timescale 1ns/1ps
module cfgld_serial import cfgld_pkg::*; #(
  parameter int AW       = 6,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic          byte_vld,
  output logic [7:0]    byte_q,
  output logic          rom_sel,
  output logic          rom_clk,
  output logic          rom_sdo,
  input  logic          rom_sdi
);
  localparam int TXB = OP_W + AW;
  localparam int TOT = TXB + 8;
  localparam int RCW = $clog2(TOT + 1);
  localparam logic [RCW-1:0] TXB_C = RCW'(TXB);
  localparam logic [RCW-1:0] TOT_C = RCW'(TOT);

  ser_st_e        st;
  logic [TXB-1:0] cmd_q;
  logic [RCW-1:0] rise_cnt;
  logic [7:0]     shreg;
  logic           tick;

  cfgld_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st != SR_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SR_IDLE;
      cmd_q    <= '0;
      rise_cnt <= '0;
      shreg    <= '0;
      rom_sel  <= 1'b0;
      rom_clk  <= 1'b0;
      rom_sdo  <= 1'b0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      unique case (st)
        SR_IDLE: if (start) begin
          cmd_q    <= {ROM_RD_OP, addr};
          rom_sdo  <= ROM_RD_OP[OP_W-1];
          rom_sel  <= 1'b1;
          rom_clk  <= 1'b0;
          rise_cnt <= '0;
          st       <= SR_SHIFT;
        end
        SR_SHIFT: if (tick) begin
          if (!rom_clk) begin
            rom_clk <= 1'b1;
            if (rise_cnt >= TXB_C) shreg <= {shreg[6:0], rom_sdi};
            rise_cnt <= rise_cnt + 1'b1;
          end else begin
            rom_clk <= 1'b0;
            if (rise_cnt == TOT_C) begin
              rom_sel <= 1'b0;
              rom_sdo <= 1'b0;
              st      <= SR_GAP;
            end else begin
              rom_sdo <= cmd_q[TXB-2];
              cmd_q   <= {cmd_q[TXB-2:0], 1'b0};
            end
          end
        end
        SR_GAP: if (tick) begin
          byte_vld <= 1'b1;
          st       <= SR_IDLE;
        end
        default: st <= SR_IDLE;
      endcase
    end
  end

  assign byte_q = shreg;

  // R2: serial clock is parked low while deselected
  p_clk_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel |-> !rom_clk);
  // R2: outgoing bit never moves on a rising serial clock edge
  p_sdo_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_clk) |-> $stable(rom_sdo));
  // R3: select stays low at least two cycles after dropping
  p_sel_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_sel) |=> !rom_sel);
endmodule

// File: rtl/cfgld_bank.sv
`timescale 1ns/1ps
module cfgld_bank #(
  parameter int NBYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NBYTES)-1:0]    wr_idx,
  input  logic [7:0]                   wr_byte,
  input  logic [$clog2(NBYTES/4)-1:0]  rd_word,
  output logic [31:0]                  rd_data
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign rd_data[8*k +: 8] = mem[{rd_word, 2'(k)}];
  end
endmodule

// File: rtl/cfgld_loader.sv
`timescale 1ns/1ps
module cfgld_loader import cfgld_pkg::*; #(
  parameter int NBYTES   = 64,
  parameter int HALF_DIV = 4,
  parameter int ROM_AW   = $clog2(NBYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        src_rom,
  output logic                        rom_sel,
  output logic                        rom_clk,
  output logic                        rom_sdo,
  input  logic                        rom_sdi,
  input  logic [$clog2(NBYTES/4)-1:0] cfg_word,
  output logic [31:0]                 cfg_data,
  output logic                        load_done
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  seq_st_e       st;
  logic [IW-1:0] idx;
  logic          start_q;
  logic          ser_vld;
  logic [7:0]    ser_byte;
  logic          wr_en;
  logic [7:0]    wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_PICK;
      idx     <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (st)
        SQ_PICK: begin
          if (src_rom) begin
            st      <= SQ_ROM;
            start_q <= 1'b1;
          end else begin
            st <= SQ_DEF;
          end
        end
        SQ_ROM: if (ser_vld) begin
          if (idx == LAST) st <= SQ_FIN;
          else begin
            idx     <= idx + 1'b1;
            start_q <= 1'b1;
          end
        end
        SQ_DEF: begin
          if (idx == LAST) st <= SQ_FIN;
          else             idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    wr_en   = ((st == SQ_ROM) && ser_vld) || (st == SQ_DEF);
    wr_byte = (st == SQ_DEF) ? dflt_byte(int'(idx)) : ser_byte;
  end

  assign load_done = (st == SQ_FIN);

  cfgld_serial #(.AW(ROM_AW), .HALF_DIV(HALF_DIV)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_q),
    .addr    (ROM_AW'(idx)),
    .byte_vld(ser_vld),
    .byte_q  (ser_byte),
    .rom_sel (rom_sel),
    .rom_clk (rom_clk),
    .rom_sdo (rom_sdo),
    .rom_sdi (rom_sdi)
  );

  cfgld_bank #(.NBYTES(NBYTES)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (idx),
    .wr_byte(wr_byte),
    .rd_word(cfg_word),
    .rd_data(cfg_data)
  );

  // R7: done is sticky and the EEPROM link is quiet afterwards
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !rom_sel);
  // R5: default source never touches the EEPROM pins
  p_def_no_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DEF) |-> (!rom_sel && !rom_clk));
  // R1: done follows the write of the highest byte
  p_last_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> ($past(wr_en) && ($past(idx) == LAST)));
endmodule

// File: tb/sim_cfgld_loader.sv
`timescale 1ns/1ps
module sim_cfgld_loader;
  localparam int NB   = 64;
  localparam int HD   = 2;
  localparam int AW   = 6;
  localparam int TXB  = 3 + AW;
  localparam int PER  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_rom = 1'b1;
  logic        rom_sel, rom_clk, rom_sdo, rom_sdi;
  logic [3:0]  cfg_word = '0;
  logic [31:0] cfg_data;
  logic        load_done;

  int tests = 0;
  int fails = 0;
  int pops = 0;
  int sel_rises = 0;
  int hp_bad = 0;
  int exp_q[$];

  logic [7:0] img [NB];
  int         bcnt = 0;
  logic [7:0] cmd_sh = '0;
  logic [8:0] got;
  logic [5:0] cur_a = '0;
  time        t_rise = 0;

  always #(PER/2) clk = ~clk;

  cfgld_loader #(.NBYTES(NB), .HALF_DIV(HD), .ROM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_rom(src_rom),
    .rom_sel(rom_sel), .rom_clk(rom_clk), .rom_sdo(rom_sdo), .rom_sdi(rom_sdi),
    .cfg_word(cfg_word), .cfg_data(cfg_data), .load_done(load_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // EEPROM model plus scoreboard monitor (R1 command order and format)
  assign rom_sdi = (rom_sel && bcnt >= TXB && bcnt < TXB + 8) ? img[cur_a][3'(TXB + 7 - bcnt)] : 1'b0;

  always @(posedge rom_clk or negedge rom_sel) begin
    if (!rom_sel) bcnt <= 0;
    else begin
      if (bcnt < TXB) cmd_sh <= {cmd_sh[6:0], rom_sdo};
      if (bcnt == TXB - 1) begin
        got   = {cmd_sh, rom_sdo};
        cur_a <= got[5:0];
        pops++;
        chk(got[8:6] == 3'b110, "R1 opcode", 32'(got[8:6]), 32'h6);
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected read", 32'(got[5:0]), 32'hFFFF_FFFF);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(32'(got[5:0]) == 32'(e), "R1 address order", 32'(got[5:0]), 32'(e));
        end
      end
      bcnt <= bcnt + 1;
    end
  end

  always @(posedge rom_sel) sel_rises++;
  always @(posedge rom_clk) t_rise = $time;
  always @(negedge rom_clk) if (rst_n === 1'b1 && t_rise != 0 && ($time - t_rise) != HD*PER) hp_bad++;

  task automatic arm_expect();
    for (int i = 0; i < NB; i++) exp_q.push_back(i);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    pops = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit, output int used);
    used = 0;
    while (!load_done && used < limit) begin
      @(negedge clk);
      used++;
    end
  endtask

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return 8'h10; 1: return 8'h97; 2: return 8'h05; 3: return 8'h98;
      8: return 8'h01; 9: return 8'h02; 10: return 8'h01; 11: return 8'h07;
      61: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_image(input bit use_dflt, input string tag);
    for (int w = 0; w < NB/4; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[8*b +: 8] = use_dflt ? dflt(4*w + b) : img[4*w + b];
      cfg_word = 4'(w);
      @(negedge clk);
      chk(cfg_data == e, tag, cfg_data, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int used;
    int rises0;
    for (int i = 0; i < NB; i++) img[i] = 8'(i*29 + 7) ^ 8'hA5;

    // Reset state (R3, R7, R8)
    do_reset();
    chk(load_done == 1'b0, "R7 done low in reset", 32'(load_done), 0);
    chk(rom_sel == 1'b0, "R3 select low in reset", 32'(rom_sel), 0);
    cfg_word = 4'd0; #1;
    chk(cfg_data == 32'h0, "R8 bank zero in reset", cfg_data, 0);

    // EEPROM load from image A
    src_rom = 1'b1;
    arm_expect();
    @(negedge clk); release_reset();
    while (pops < 6) @(negedge clk);
    chk(rom_sel == 1'b1, "R3 select high during transfer", 32'(rom_sel), 1);
    chk(load_done == 1'b0, "R7 done low while loading", 32'(load_done), 0);
    cfg_word = 4'd15; @(negedge clk);
    chk(cfg_data == 32'h0, "R8 unloaded word reads zero", cfg_data, 0);
    cfg_word = 4'd0; @(negedge clk);
    chk(cfg_data == {img[3], img[2], img[1], img[0]}, "R8 R4 partial word", cfg_data, {img[3], img[2], img[1], img[0]});
    src_rom = 1'b0;   // R6: ignored after the first cycle
    wait_done(20000, used);
    chk(load_done == 1'b1, "R7 done after load", 32'(load_done), 1);
    chk(exp_q.size() == 0, "R1 all addresses read", 32'(exp_q.size()), 0);
    chk(hp_bad == 0, "R2 serial half period", 32'(hp_bad), 0);
    check_image(1'b0, "R4 R6 image A contents");
    repeat (20) @(negedge clk);
    chk(load_done == 1'b1 && rom_sel == 1'b0, "R7 done sticky, link idle", {30'h0, load_done, rom_sel}, 32'h2);

    // Reset mid-load, new image (R9)
    for (int i = 0; i < NB; i++) img[i] = 8'(255 - i*3);
    src_rom = 1'b1;
    do_reset();
    arm_expect();
    @(negedge clk); release_reset();
    while (pops < 10) @(negedge clk);
    do_reset();
    cfg_word = 4'd0; #1;
    chk(cfg_data == 32'h0, "R9 bank cleared by reset", cfg_data, 0);
    chk(rom_sel == 1'b0, "R9 transfer stopped", 32'(rom_sel), 0);
    arm_expect();
    @(negedge clk); release_reset();
    wait_done(20000, used);
    chk(load_done == 1'b1, "R9 restarted load completes", 32'(load_done), 1);
    chk(exp_q.size() == 0, "R9 addresses from zero", 32'(exp_q.size()), 0);
    check_image(1'b0, "R9 image B contents");

    // Default source (R5, R6, R7)
    src_rom = 1'b0;
    do_reset();
    rises0 = sel_rises;
    @(negedge clk); release_reset();
    repeat (3) @(negedge clk);
    src_rom = 1'b1;   // R6: late change ignored
    wait_done(200, used);
    chk(used <= NB + 4, "R7 default load time", 32'(used), NB + 4);
    check_image(1'b1, "R5 default contents");
    repeat (200) @(negedge clk);
    chk(sel_rises == rises0, "R5 R6 no EEPROM access", 32'(sel_rises), 32'(rises0));
    chk(load_done == 1'b1, "R7 done held", 32'(load_done), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule